// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a bank of 32 general-purpose pins placed behind a small 32-bit register bus. Software picks each pin's direction through two strobe registers. One register turns pins into outputs and the other turns them back into inputs. In both registers a zero bit means "leave alone", so no read-modify-write is needed to change a single pin.

Output levels are written through two half-word registers, one for the low sixteen pins and one for the high sixteen. Each write carries its own per-bit enable mask in the upper half-word. A driver can therefore flip one pin with a single store, and two agents sharing the port cannot overwrite each other's pins.

The output latch drives the pin data line at all times, whatever the direction. A level loaded while a pin is still an input is already present when the pin turns to output, so the switch causes no glitch. Pin levels pass through a two-stage synchronizer before they can be read. All outputs, including read data, come from registers.

Top module: `gpio_mask_port`

## Requirements
- R1: After a synchronous reset, pin_oe is all zero, pin_out is all zero and bus_rdata is zero.
- R2: A write to byte address 0x00 sets to 1 every pin_oe bit whose write-data bit is 1, leaving the other pin_oe bits unchanged; the new value is visible after the clock edge that accepts the write.
- R3: A write to byte address 0x04 clears to 0 every pin_oe bit whose write-data bit is 1, leaving the other pin_oe bits unchanged.
- R4: A write to address 0x08 updates pin_out[i] for i in 0..15 to write-data bit i when write-data bit i+16 is 1.
- R5: A write to address 0x0C updates pin_out[16+i] to write-data bit i when write-data bit i+16 is 1.
- R6: Output bits whose mask bit is 0 keep their value; a write with an all-zero mask changes nothing.
- R7: A read of address 0x10 returns pin_in as it was three clock edges before the edge that returns the data (two synchronizer stages plus the read register).
- R8: A read of 0x08 or 0x0C returns that half's sixteen output levels in bits 15:0, with bits 31:16 zero.
- R9: A read of 0x00 returns the current direction vector (1 = output).
- R10: pin_out follows the output latch regardless of direction; a level loaded while a pin is an input is already on pin_out when the pin becomes an output, and pin_out does not change on the direction switch.
- R11: Writes to 0x10 or to any unmapped address change neither pin_out nor pin_oe.
- R12: Read data appears on bus_rdata one cycle after the read is accepted; reads of unmapped addresses return zero and reads change no pin state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels seen from outside |
| pin_out | output | 32 | Output latch levels |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |

## Verification
The checker assumes that pin_in and the bus inputs hold known values from the first clock edge. This matters because the synchronizer stages have no reset, and the input-read property compares read data with pin_in three edges back. It also assumes that a single access is presented per cycle, with bus_wr qualified by bus_sel. The bench drives every input from time zero, changes stimulus only on the falling clock edge, and keeps bus_sel low between accesses, which keeps the stimulus inside those assumptions.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Byte offsets of the register window; decoders compare the full address.
  localparam int OFS_DIR_SET = 'h00;
  localparam int OFS_DIR_CLR = 'h04;
  localparam int OFS_OUT_LO  = 'h08;
  localparam int OFS_OUT_HI  = 'h0C;
  localparam int OFS_PIN_IN  = 'h10;
  localparam int NUM_HALVES  = 2;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-stage synchronizer for asynchronous pin levels. Left without reset so
// the flops map onto plain registers.
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    stage1   <= async_in;
    sync_out <= stage1;
  end
endmodule

// File: rtl/gpio_dir_reg.sv
// Direction vector updated by independent set and clear strobes.
module gpio_dir_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_bits,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) dir_q <= '0;
    else     dir_q <= (dir_q | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/gpio_out_half.sv
// One half-word of output latches; each bit loads only when its mask bit is set.
module gpio_out_half #(
  parameter int HALF = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [HALF-1:0] wr_mask,
  input  logic [HALF-1:0] wr_val,
  output logic [HALF-1:0] lvl_q
);
  for (genvar b = 0; b < HALF; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        lvl_q[b] <= 1'b0;
      else if (wr_en && wr_mask[b])   lvl_q[b] <= wr_val[b];
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  localparam int HALF = NPIN / 2;

  logic wr_cyc, rd_cyc;
  logic hit_set, hit_clr, hit_in;
  logic [NUM_HALVES-1:0] hit_out;
  logic [NPIN-1:0] in_sync;

  assign wr_cyc  = bus_sel &&  bus_wr;
  assign rd_cyc  = bus_sel && !bus_wr;
  assign hit_set = bus_addr == ADDR_W'(OFS_DIR_SET);
  assign hit_clr = bus_addr == ADDR_W'(OFS_DIR_CLR);
  assign hit_in  = bus_addr == ADDR_W'(OFS_PIN_IN);
  assign hit_out[0] = bus_addr == ADDR_W'(OFS_OUT_LO);
  assign hit_out[1] = bus_addr == ADDR_W'(OFS_OUT_HI);

  gpio_in_sync #(.WIDTH(NPIN)) i_sync (
    .clk      (clk),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_dir_reg #(.WIDTH(NPIN)) i_dir (
    .clk      (clk),
    .rst      (rst),
    .set_bits ((wr_cyc && hit_set) ? bus_wdata : '0),
    .clr_bits ((wr_cyc && hit_clr) ? bus_wdata : '0),
    .dir_q    (pin_oe)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    gpio_out_half #(.HALF(HALF)) i_half (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_cyc && hit_out[h]),
      .wr_mask (bus_wdata[NPIN-1:HALF]),
      .wr_val  (bus_wdata[HALF-1:0]),
      .lvl_q   (pin_out[h*HALF +: HALF])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_cyc) begin
      if (hit_set)         bus_rdata <= pin_oe;
      else if (hit_out[0]) bus_rdata <= {{HALF{1'b0}}, pin_out[HALF-1:0]};
      else if (hit_out[1]) bus_rdata <= {{HALF{1'b0}}, pin_out[NPIN-1:HALF]};
      else if (hit_in)     bus_rdata <= in_sync;
      else                 bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe
);
  localparam int H = NPIN / 2;
  logic w_set, w_clr, w_lo, r_in, r_half, w_any;
  assign w_any  = bus_sel && bus_wr;
  assign w_set  = w_any && bus_addr == ADDR_W'('h00);
  assign w_clr  = w_any && bus_addr == ADDR_W'('h04);
  assign w_lo   = w_any && bus_addr == ADDR_W'('h08);
  assign r_in   = bus_sel && !bus_wr && bus_addr == ADDR_W'('h10);
  assign r_half = bus_sel && !bus_wr &&
                  (bus_addr == ADDR_W'('h08) || bus_addr == ADDR_W'('h0C));

  a_r2_dir_set: assert property (@(posedge clk) disable iff (rst)
    w_set |=> (pin_oe & $past(bus_wdata)) == $past(bus_wdata));

  a_r3_dir_clr: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> (pin_oe & $past(bus_wdata)) == '0);

  a_r6_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
    w_lo |=> (pin_out[H-1:0] & ~$past(bus_wdata[NPIN-1:H])) ==
             ($past(pin_out[H-1:0]) & ~$past(bus_wdata[NPIN-1:H])));

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !w_any |=> $stable(pin_out) && $stable(pin_oe));

  a_r7_in_latency: assert property (@(posedge clk) disable iff (rst)
    r_in |=> bus_rdata == $past(pin_in, 3));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    r_half |=> bus_rdata[NPIN-1:H] == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(8'h00, rd); check("R9 dir after reset", rd, 32'h0);
  endtask

  task automatic t_direction();
    bus_write(8'h00, 32'h0000_00F0); check("R2 set", pin_oe, 32'h0000_00F0);
    bus_write(8'h00, 32'h0F00_0001); check("R2 set keeps others", pin_oe, 32'h0F00_00F1);
    bus_write(8'h04, 32'h0000_0030); check("R3 clear", pin_oe, 32'h0F00_00C1);
    bus_read(8'h00, rd); check("R9 dir read", rd, 32'h0F00_00C1);
  endtask

  task automatic t_outputs();
    bus_write(8'h08, 32'hFFFF_A5A5); check("R4 low full", pin_out, 32'h0000_A5A5);
    bus_write(8'h08, 32'h0001_0000); check("R4 low single", pin_out, 32'h0000_A5A4);
    bus_write(8'h08, 32'h0000_FFFF); check("R6 zero mask", pin_out, 32'h0000_A5A4);
    bus_write(8'h0C, 32'h8000_FFFF); check("R5 high single", pin_out, 32'h8000_A5A4);
    bus_read(8'h08, rd); check("R8 low read", rd, 32'h0000_A5A4);
    bus_read(8'h0C, rd); check("R8 high read", rd, 32'h0000_8000);
    check("R12 reads keep pins", pin_out, 32'h8000_A5A4);
  endtask

  task automatic t_preload();
    bus_write(8'h04, 32'hFFFF_FFFF); check("R3 clear all", pin_oe, 32'h0);
    bus_write(8'h0C, 32'h0004_0004);
    check("R10 latch while input", pin_out, 32'h8004_A5A4);
    check("R10 still input", pin_oe, 32'h0);
    bus_write(8'h00, 32'h0004_0000);
    check("R10 oe on", pin_oe, 32'h0004_0000);
    check("R10 level kept", pin_out, 32'h8004_A5A4);
  endtask

  task automatic t_input();
    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_read(8'h10, rd); check("R7 steady", rd, 32'h1234_5678);
    pin_in = 32'hCAFE_F00D;
    bus_read(8'h10, rd); check("R7 stage1 old", rd, 32'h1234_5678);
    bus_read(8'h10, rd); check("R7 stage2 old", rd, 32'h1234_5678);
    bus_read(8'h10, rd); check("R7 new value", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_ignored();
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h0A, 32'hFFFF_FFFF);
    check("R11 out kept", pin_out, 32'h8004_A5A4);
    check("R11 oe kept", pin_oe, 32'h0004_0000);
    bus_read(8'h1C, rd); check("R12 unmapped read", rd, 32'h0);
    bus_read(8'h00, rd); check("R12 latency dir", rd, 32'h0004_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direction();
    t_outputs();
    t_preload();
    t_input();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule